// File: doc/BRIEF.md
# Indexed Pixel Pipeline with Cursor Overlay

This block turns a stream of indexed pixels into 24-bit RGB. Each input beat carries the raster position (x, y) and an 8-bit colour index. Outside the hardware cursor, the index is looked up in an external 256-entry colour table through a read port with one cycle of latency. Inside a 64x64 cursor window, a 2-bit code from a pattern held in the block decides the output. Code 0 lets the indexed pixel through. Codes 1 to 3 substitute one of three cursor colours. A blanking control forces every outgoing pixel to black.

The pattern is stored as 512 words of 16 bits, eight words per cursor row, and is loaded through a simple write port. The cursor position arrives as one 24-bit word: the column sits in the upper twelve bits and the row in the lower twelve. Window comparisons are done with signed 13-bit differences, so a cursor placed near the right or bottom edge is clipped rather than wrapped.

Both stream edges use valid/ready handshakes. A beat moves when valid and ready are both high at a rising clock edge. When the output holds a pixel that the consumer has not taken, the whole two-stage pipeline freezes and `in_ready` drops. Otherwise the block accepts one pixel per cycle. The output data is stable for as long as it is offered and not taken.

Top module: `pix_cursor_pipe`

## Requirements
- R1: A pixel outside the cursor window leaves as the colour table entry at its index, two clock edges after it is accepted, and pixels leave in the order they were accepted.
- R2: The cursor column is `cur_pos[23:12]` and the row is `cur_pos[11:0]`. A pixel lies in the window when row ≤ y < row+64 and column ≤ x < column+64.
- R3: Inside the window, the pattern word used is (y−row)*8 + (x−column)/8. The 2-bit code is taken from bits [2*s+1:2*s] of that word, where s = (x−column) mod 8.
- R4: Code 0 outputs the colour table entry for the index. Codes 1, 2 and 3 output `cur_colors[23:0]`, `cur_colors[47:24]` and `cur_colors[71:48]` respectively.
- R5: While `ctl_cursor_off` is high when a pixel is accepted, that pixel takes the colour table entry regardless of the pattern.
- R6: While `ctl_blank` is high, every pixel that reaches the output has RGB value zero, and it is still delivered with `out_valid`.
- R7: While `out_valid` is high and `out_ready` is low, `out_rgb` and `out_valid` hold and no input beat is accepted.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: Window tests do not wrap around the 12-bit coordinate range. With the cursor near the maximum coordinate, pixels at small x or y are outside the window.
- R10: With `out_ready` held high, one pixel is accepted on every cycle with no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Input pixel accepted this edge when valid |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_index | input | 8 | Colour index of the pixel |
| out_valid | output | 1 | Output pixel offered |
| out_ready | input | 1 | Consumer takes output pixel |
| out_rgb | output | 24 | Output colour, R in bits 23:16 |
| cur_pos | input | 24 | Cursor column [23:12] and row [11:0] |
| ctl_cursor_off | input | 1 | Suppress the cursor overlay |
| ctl_blank | input | 1 | Force black output |
| cur_colors | input | 72 | Three cursor colours, code k at [24k-1:24k-24] |
| pal_raddr | output | 8 | Colour table read address |
| pal_rdata | input | 24 | Colour table data, one cycle after address |
| pat_we | input | 1 | Pattern word write enable |
| pat_waddr | input | 9 | Pattern word address |
| pat_wdata | input | 16 | Pattern word data |

## Verification
The bench probes the window borders on all four sides. An off-by-one compare would paint a cursor colour one column or row too far, or drop the first column or row. It sweeps full cursor rows so that every code slot of every word is used. A wrong word index or a reversed bit order would show a shifted or mirrored pattern. It places the cursor near the top of the coordinate range. Unsigned modular arithmetic there would wrap the cursor onto pixels at the left or top edge. It also throttles `out_ready` irregularly. A colour table address that is not held during a stall would make the frozen pixel pick up the next pixel's colour.

// File: rtl/pix_cursor_pkg.sv
package pix_cursor_pkg;
  // Coordinate width, index width, colour width
  localparam int unsigned COORD_W = 12;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned RGB_W   = 24;
  // Cursor geometry
  localparam int unsigned CUR_DIM = 64;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned CODE_W  = 2;
  localparam int unsigned N_CCOL  = 3;

  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_CLEAR = '0;
endpackage

// File: rtl/cursor_locate.sv
module cursor_locate
  import pix_cursor_pkg::*;
#(
  parameter int unsigned CW  = COORD_W,
  parameter int unsigned DIM = CUR_DIM,
  parameter int unsigned WW  = WORD_W,
  localparam int unsigned PPW   = WW / CODE_W,
  localparam int unsigned DBITS = $clog2(DIM),
  localparam int unsigned PBITS = $clog2(PPW),
  localparam int unsigned AW    = 2 * DBITS - PBITS,
  localparam int unsigned SW    = CW + 1
) (
  input  logic [CW-1:0]    x,
  input  logic [CW-1:0]    y,
  input  logic [2*CW-1:0]  pos,
  input  logic             suppress,
  output logic             hit,
  output logic [AW-1:0]    word_addr,
  output logic [PBITS-1:0] slot
);
  localparam logic signed [SW-1:0] DIM_S = SW'(DIM);

  logic signed [SW-1:0] dx, dy;
  logic in_x, in_y;

  always_comb begin
    dx   = $signed({1'b0, x}) - $signed({1'b0, pos[2*CW-1:CW]});
    dy   = $signed({1'b0, y}) - $signed({1'b0, pos[CW-1:0]});
    in_x = (dx >= 0) && (dx < DIM_S);
    in_y = (dy >= 0) && (dy < DIM_S);
    hit  = !suppress && in_x && in_y;
    // row * words-per-row + column / pixels-per-word
    word_addr = {dy[DBITS-1:0], dx[DBITS-1:PBITS]};
    slot      = dx[PBITS-1:0];
  end
endmodule

// File: rtl/cursor_store.sv
module cursor_store
  import pix_cursor_pkg::*;
#(
  parameter int unsigned WW    = WORD_W,
  parameter int unsigned WORDS = 512,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/colour_pick.sv
module colour_pick
  import pix_cursor_pkg::*;
#(
  parameter int unsigned WW   = WORD_W,
  parameter int unsigned CBW  = RGB_W,
  parameter int unsigned NCOL = N_CCOL,
  localparam int unsigned PBITS = $clog2(WW / CODE_W)
) (
  input  logic [WW-1:0]       word,
  input  logic [PBITS-1:0]    slot,
  input  logic                hit,
  input  logic                blank,
  input  logic [CBW-1:0]      table_rgb,
  input  logic [NCOL*CBW-1:0] ccols,
  output logic [CBW-1:0]      rgb
);
  code_t code;
  logic [CBW-1:0] ccol [NCOL+1];

  assign ccol[0] = table_rgb;
  for (genvar k = 0; k < NCOL; k++) begin : g_ccol
    assign ccol[k+1] = ccols[k*CBW +: CBW];
  end

  always_comb begin
    code = word[CODE_W*slot +: CODE_W];
    if (blank)                         rgb = '0;
    else if (hit && code != CODE_CLEAR) rgb = ccol[code];
    else                               rgb = table_rgb;
  end
endmodule

// File: rtl/pix_cursor_pipe.sv
module pix_cursor_pipe
  import pix_cursor_pkg::*;
#(
  parameter int unsigned CW   = COORD_W,
  parameter int unsigned IW   = IDX_W,
  parameter int unsigned CBW  = RGB_W,
  parameter int unsigned DIM  = CUR_DIM,
  parameter int unsigned WW   = WORD_W,
  parameter int unsigned NCOL = N_CCOL,
  localparam int unsigned PPW   = WW / CODE_W,
  localparam int unsigned WORDS = DIM * DIM / PPW,
  localparam int unsigned AW    = $clog2(WORDS),
  localparam int unsigned PBITS = $clog2(PPW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CW-1:0]       in_x,
  input  logic [CW-1:0]       in_y,
  input  logic [IW-1:0]       in_index,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CBW-1:0]      out_rgb,
  input  logic [2*CW-1:0]     cur_pos,
  input  logic                ctl_cursor_off,
  input  logic                ctl_blank,
  input  logic [NCOL*CBW-1:0] cur_colors,
  output logic [IW-1:0]       pal_raddr,
  input  logic [CBW-1:0]      pal_rdata,
  input  logic                pat_we,
  input  logic [AW-1:0]       pat_waddr,
  input  logic [WW-1:0]       pat_wdata
);
  logic             adv;
  logic             s0_hit;
  logic [AW-1:0]    s0_addr;
  logic [PBITS-1:0] s0_slot;
  logic             s1_valid, s1_hit;
  logic [PBITS-1:0] s1_slot;
  logic [IW-1:0]    s1_index;
  logic [WW-1:0]    s1_word;
  logic [CBW-1:0]   s1_rgb;

  // Whole pipe advances unless the output holds an untaken pixel
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  // Hold the table address on a stall so its data stays aligned with stage 1
  assign pal_raddr = adv ? in_index : s1_index;

  cursor_locate #(.CW(CW), .DIM(DIM), .WW(WW)) u_locate (
    .x(in_x), .y(in_y), .pos(cur_pos), .suppress(ctl_cursor_off),
    .hit(s0_hit), .word_addr(s0_addr), .slot(s0_slot)
  );

  cursor_store #(.WW(WW), .WORDS(WORDS)) u_store (
    .clk(clk), .we(pat_we), .waddr(pat_waddr), .wdata(pat_wdata),
    .re(adv), .raddr(s0_addr), .rdata(s1_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_slot  <= '0;
      s1_index <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_hit   <= s0_hit;
      s1_slot  <= s0_slot;
      s1_index <= in_index;
    end
  end

  colour_pick #(.WW(WW), .CBW(CBW), .NCOL(NCOL)) u_pick (
    .word(s1_word), .slot(s1_slot), .hit(s1_hit), .blank(ctl_blank),
    .table_rgb(pal_rdata), .ccols(cur_colors), .rgb(s1_rgb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      if (s1_valid) out_rgb <= s1_rgb;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb));
  // R7
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(s1_valid) && $stable(s1_index));
  // R10
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);
  // R10
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && in_ready |=> out_valid);
  // R6
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && in_ready && ctl_blank |=> out_valid && out_rgb == '0);
endmodule

// File: tb/pix_cursor_pipe_tb.sv
module pix_cursor_pipe_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 1'b0, in_ready;
  logic [11:0] in_x = '0, in_y = '0;
  logic [7:0]  in_index = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [23:0] out_rgb;
  logic [23:0] cur_pos = '0;
  logic        ctl_cursor_off = 1'b0, ctl_blank = 1'b0;
  logic [71:0] cur_colors = {24'hC0FFEE, 24'h123456, 24'hABCDEF};
  logic [7:0]  pal_raddr;
  logic [23:0] pal_rdata;
  logic        pat_we = 1'b0;
  logic [8:0]  pat_waddr = '0;
  logic [15:0] pat_wdata = '0;

  pix_cursor_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_index(in_index), .out_valid(out_valid),
    .out_ready(out_ready), .out_rgb(out_rgb), .cur_pos(cur_pos),
    .ctl_cursor_off(ctl_cursor_off), .ctl_blank(ctl_blank),
    .cur_colors(cur_colors), .pal_raddr(pal_raddr), .pal_rdata(pal_rdata),
    .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wdata(pat_wdata)
  );

  // Colour table with one cycle of read latency
  logic [23:0] pal_mem [256];
  logic [15:0] pat_m [512];
  always_ff @(posedge clk) pal_rdata <= pal_mem[pal_raddr];

  int checks = 0, errors = 0;
  logic [23:0] exp_rgb [1024];
  string       exp_tag [1024];
  int wr = 0, rd = 0;
  int waits = 0;
  bit done = 0;

  task automatic report(bit ok, string tag, logic [23:0] act, logic [23:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Expected colour from the requirements
  function automatic logic [23:0] model(logic [11:0] x, logic [11:0] y, logic [7:0] idx);
    int dx, dy, code;
    logic [15:0] w;
    if (ctl_blank) return 24'h0;
    dx = int'(x) - int'(cur_pos[23:12]);
    dy = int'(y) - int'(cur_pos[11:0]);
    if (!ctl_cursor_off && dx >= 0 && dx < 64 && dy >= 0 && dy < 64) begin
      w = pat_m[dy*8 + dx/8];
      code = int'((w >> (2*(dx%8))) & 16'h3);
      if (code != 0) return cur_colors[(code-1)*24 +: 24];
    end
    return pal_mem[idx];
  endfunction

  task automatic send(logic [11:0] x, logic [11:0] y, logic [7:0] idx, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_x = x; in_y = y; in_index = idx;
    #1;
    while (!in_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    exp_rgb[wr] = model(x, y, idx);
    exp_tag[wr] = tag;
    wr++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Back-to-back sender for throughput
  task automatic send_burst(int n, logic [11:0] x0, logic [11:0] y0, string tag);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_x = x0 + 12'(i); in_y = y0; in_index = 8'(i*7);
      #1;
      while (!in_ready) begin
        waits++;
        @(negedge clk);
        #1;
      end
      exp_rgb[wr] = model(in_x, in_y, in_index);
      exp_tag[wr] = tag;
      wr++;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain(string tag);
    repeat (8) @(negedge clk);
    report(rd == wr, tag, 24'(rd), 24'(wr));
  endtask

  // Output monitor: compares each delivered pixel, checks stall hold
  bit prev_stall = 0;
  logic [23:0] prev_rgb;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (prev_stall) report(out_valid && out_rgb == prev_rgb, "R7 hold", out_rgb, prev_rgb);
      prev_stall = out_valid && !out_ready;
      prev_rgb = out_rgb;
      if (out_valid && out_ready) begin
        if (rd < wr) begin
          report(out_rgb == exp_rgb[rd], exp_tag[rd], out_rgb, exp_rgb[rd]);
          rd++;
        end else begin
          report(1'b0, "R1 unexpected output", out_rgb, 24'h0);
        end
      end
    end
  end

  task automatic t_reset();
    // R8
    report(!out_valid, "R8 out_valid after reset", 24'(out_valid), 24'h0);
    report(in_ready, "R8 in_ready after reset", 24'(in_ready), 24'h1);
  endtask

  task automatic t_load_pattern();
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      pat_we = 1'b1; pat_waddr = 9'(i);
      pat_wdata = 16'(i * 40503 + 12345) ^ 16'(i << 7);
      pat_m[i] = pat_wdata;
    end
    @(negedge clk);
    pat_we = 1'b0;
  endtask

  task automatic t_plain();
    // R1 and R5: cursor off over the window area; colour table only
    cur_pos = {12'd10, 12'd10};
    ctl_cursor_off = 1'b1;
    for (int i = 0; i < 12; i++) send(12'(10 + i*5), 12'(10 + i), 8'(i*21), "R5 cursor off");
    send(12'd500, 12'd500, 8'hFF, "R1 outside");
    send(12'd0, 12'd0, 8'h00, "R1 origin");
    ctl_cursor_off = 1'b0;
    send(12'd300, 12'd7, 8'h3C, "R1 outside window");
    drain("R1 drain");
  endtask

  task automatic t_borders();
    // R2: edges at column 100..163, row 50..113
    cur_pos = {12'd100, 12'd50};
    send(12'd99,  12'd60,  8'h11, "R2 left outside");
    send(12'd100, 12'd60,  8'h11, "R2 left inside");
    send(12'd163, 12'd60,  8'h22, "R2 right inside");
    send(12'd164, 12'd60,  8'h22, "R2 right outside");
    send(12'd120, 12'd49,  8'h33, "R2 top outside");
    send(12'd120, 12'd50,  8'h33, "R2 top inside");
    send(12'd120, 12'd113, 8'h44, "R2 bottom inside");
    send(12'd120, 12'd114, 8'h44, "R2 bottom outside");
    drain("R2 drain");
  endtask

  task automatic t_sweep();
    // R3 and R4: every slot of every word on several rows; R10 throughput
    cur_pos = {12'd200, 12'd300};
    waits = 0;
    send_burst(64, 12'd200, 12'd300, "R3 row 0");
    send_burst(64, 12'd200, 12'd301, "R4 row 1");
    send_burst(64, 12'd200, 12'd302, "R3 row 2");
    send_burst(64, 12'd200, 12'd331, "R4 row 31");
    send_burst(64, 12'd200, 12'd363, "R3 row 63");
    report(waits == 0, "R10 no waits", 24'(waits), 24'h0);
    drain("R3 drain");
  endtask

  task automatic t_edge();
    // R9: cursor near the top of the coordinate range, no wrap
    cur_pos = {12'd4070, 12'd4090};
    send(12'd4095, 12'd4095, 8'h55, "R9 inside corner");
    send(12'd4070, 12'd4090, 8'h56, "R9 inside origin");
    send(12'd5,    12'd4095, 8'h57, "R9 wrapped x outside");
    send(12'd4080, 12'd3,    8'h58, "R9 wrapped y outside");
    send(12'd10,   12'd10,   8'h59, "R9 both wrapped outside");
    drain("R9 drain");
  endtask

  task automatic t_blank();
    // R6
    cur_pos = {12'd0, 12'd0};
    ctl_blank = 1'b1;
    for (int i = 0; i < 8; i++) send(12'(i*9), 12'(i*3), 8'(i*31 + 1), "R6 blank");
    drain("R6 drain");
    ctl_blank = 1'b0;
  endtask

  task automatic t_backpressure();
    // R7: irregular consumer
    cur_pos = {12'd20, 12'd20};
    fork
      send_burst(100, 12'd0, 12'd40, "R7 throttled");
      begin
        for (int i = 0; i < 400; i++) begin
          @(negedge clk);
          out_ready = (i % 3 != 0) && (i % 7 != 2);
        end
        @(negedge clk);
        out_ready = 1'b1;
      end
    join
    drain("R7 drain");
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) pal_mem[i] = {8'(i), ~8'(i), 8'(i) ^ 8'h5A};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    t_load_pattern();
    t_plain();
    t_borders();
    t_sweep();
    t_edge();
    t_blank();
    t_backpressure();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule